// File: doc/BRIEF.md
# Routing Junction Switch

This block is the switch at one crossing point of a programmable routing fabric. Several wires meet there: the output and the input of the local logic gate, an incoming and an outgoing up/right short segment, an incoming and an outgoing down/left short segment, and a shared long line that crosses the whole array. A 10-bit configuration word enables any subset of the ten legal connections among these wires. No other pairing can be expressed. Each wire is `W` bits wide, so one instance can serve several parallel fabric slices.

A value taken from an incoming short segment is inverted on its way through the junction. A value taken from the long line or from the gate output passes through unchanged. The gate output can be routed directly, or through an output flip-flop that every gate-output connection then uses. The long-line driver is either a plain driver or a tristate driver whose enable is the down/left output value. When the configuration gives any destination wire more than one driver, the block raises an error and mutes that wire.

All outputs are registered once, with a synchronous active-high reset.

Top module: `route_junction`

## Requirements
- R1: During and directly after a synchronous reset, every output is zero and `cfg_err` is low.
- R2: Bit k of `conn_en` enables exactly one connection. Bits 0 and 2 connect the gate output to the gate input. Bit 1 connects the incoming down/left segment to the outgoing down/left segment. Bit 3 connects the gate output to the long line. Bit 4 connects the incoming up/right segment to the outgoing up/right segment. Bit 5 connects the gate output to the outgoing down/left segment. Bit 6 connects the incoming down/left segment to the gate input. Bit 7 connects the gate output to the outgoing up/right segment. Bit 8 connects the long line to the gate input. Bit 9 connects the incoming up/right segment to the gate input.
- R3: A connection whose source is `ru_in` or `ld_in` delivers the bitwise inverse of that input. Connections whose source is the gate output or `long_rd` deliver the value unchanged.
- R4: A destination wire with no enabled connection outputs zero. For the long line, `long_oe` is also zero.
- R5: Every output reflects the inputs sampled at the previous rising clock edge, which is a latency of one cycle.
- R6: With `reg_out` high, every gate-output connection (bits 0, 2, 3, 5, 7) carries the `gate_out` value that was sampled one clock edge before the inputs in use.
- R7: If two or more enabled connections share a destination wire, `cfg_err` is high and that wire outputs zero. Wires that have a single driver are unaffected.
- R8: With `tri_mode` low, bit 3 drives `long_drv` and sets every bit of `long_oe`. When bit 3 is clear, `long_oe` is zero.
- R9: With `tri_mode` high and bit 3 set, `long_oe` equals the value the junction places on `ld_out`. That value is zero when `ld_out` is undriven or in conflict.
- R10: Bit 8 places the sampled `long_rd` value on the gate input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conn_en | input | 10 | Connection enable word |
| reg_out | input | 1 | Route the gate output through the output flip-flop |
| tri_mode | input | 1 | Long-line driver enabled by the down/left output |
| gate_out | input | W | Output of the local gate |
| ru_in | input | W | Incoming up/right segment |
| ld_in | input | W | Incoming down/left segment |
| long_rd | input | W | Resolved value of the long line |
| gate_in | output | W | Value delivered to the gate input |
| ru_out | output | W | Outgoing up/right segment |
| ld_out | output | W | Outgoing down/left segment |
| long_drv | output | W | Value driven onto the long line |
| long_oe | output | W | Per-bit enable of the long-line driver |
| cfg_err | output | 1 | Multiple drivers on one wire |

## Verification
Assertions check the following on every cycle:
- A doubly driven gate input or down/left output raises the error flag and mutes that wire.
- A legal configuration never raises the error flag.
- With bit 3 clear, the long driver is silent.
- With bit 3 set in plain mode, the long driver is fully enabled.
- When the output flip-flop is selected, the source value is the gate output from one edge earlier.

The following are shown only by the bench scenarios, which compare the outputs with a behavioural model on every clock:
- the inversion of values taken from short segments;
- the exact two-edge delay through the registered output;
- the long-line read-back into the gate input;
- the tristate enable that follows the down/left output.

// File: rtl/junction_pkg.sv
package junction_pkg;
  localparam int unsigned N_CONN = 10;

  // Connection bit positions inside the enable word.
  localparam int unsigned K_GO_GI_A = 0;
  localparam int unsigned K_LD_LD   = 1;
  localparam int unsigned K_GO_GI_B = 2;
  localparam int unsigned K_GO_LONG = 3;
  localparam int unsigned K_RU_RU   = 4;
  localparam int unsigned K_GO_LD   = 5;
  localparam int unsigned K_LD_GI   = 6;
  localparam int unsigned K_GO_RU   = 7;
  localparam int unsigned K_LONG_GI = 8;
  localparam int unsigned K_RU_GI   = 9;

  typedef enum logic [1:0] {
    DST_GI   = 2'd0,
    DST_RU   = 2'd1,
    DST_LD   = 2'd2,
    DST_LONG = 2'd3
  } dest_e;

  localparam int unsigned N_DEST = 4;

  function automatic dest_e dest_of(input int unsigned k);
    case (k)
      K_LD_LD, K_GO_LD:  dest_of = DST_LD;
      K_RU_RU, K_GO_RU:  dest_of = DST_RU;
      K_GO_LONG:         dest_of = DST_LONG;
      default:           dest_of = DST_GI;
    endcase
  endfunction
endpackage

// File: rtl/junction_src.sv
module junction_src #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         reg_out,
  input  logic [W-1:0] gate_out,
  output logic [W-1:0] src_val
);
  logic [W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) hold_q <= '0;
    else     hold_q <= gate_out;
  end

  assign src_val = reg_out ? hold_q : gate_out;

  // R6: registered path carries the gate output from one edge earlier
  p_reg_path_r6: assert property (@(posedge clk) disable iff (rst)
    (reg_out && $past(!rst)) |-> (src_val == $past(gate_out)));
endmodule

// File: rtl/junction_conflict.sv
module junction_conflict
  import junction_pkg::*;
(
  input  logic [N_CONN-1:0] conn_en,
  output logic [N_DEST-1:0] clash
);
  localparam int unsigned CW = $clog2(N_CONN + 1);

  for (genvar d = 0; d < N_DEST; d++) begin : g_dest
    logic [CW-1:0] drivers;
    always_comb begin
      drivers = '0;
      for (int unsigned k = 0; k < N_CONN; k++)
        if (conn_en[k] && (dest_of(k) == dest_e'(d)))
          drivers = drivers + CW'(1);
    end
    assign clash[d] = (drivers > CW'(1));
  end
endmodule

// File: rtl/junction_route.sv
module junction_route
  import junction_pkg::*;
#(
  parameter int unsigned W = 1
) (
  input  logic [N_CONN-1:0] conn_en,
  input  logic [N_DEST-1:0] clash,
  input  logic              tri_mode,
  input  logic [W-1:0]      src_val,
  input  logic [W-1:0]      ru_in,
  input  logic [W-1:0]      ld_in,
  input  logic [W-1:0]      long_rd,
  output logic [W-1:0]      gi_nxt,
  output logic [W-1:0]      ru_nxt,
  output logic [W-1:0]      ld_nxt,
  output logic [W-1:0]      long_nxt,
  output logic [W-1:0]      oe_nxt
);
  logic [W-1:0] cand [N_CONN];

  // Value each connection would deliver; short-segment sources invert.
  always_comb begin
    for (int unsigned k = 0; k < N_CONN; k++) begin
      case (k)
        K_LD_LD, K_LD_GI:  cand[k] = ~ld_in;
        K_RU_RU, K_RU_GI:  cand[k] = ~ru_in;
        K_LONG_GI:         cand[k] = long_rd;
        default:           cand[k] = src_val;
      endcase
    end
  end

  logic [W-1:0] merged [N_DEST];

  for (genvar d = 0; d < N_DEST; d++) begin : g_merge
    always_comb begin
      merged[d] = '0;
      for (int unsigned k = 0; k < N_CONN; k++)
        if (conn_en[k] && (dest_of(k) == dest_e'(d)))
          merged[d] = merged[d] | cand[k];
      if (clash[d]) merged[d] = '0;
    end
  end

  assign gi_nxt   = merged[DST_GI];
  assign ru_nxt   = merged[DST_RU];
  assign ld_nxt   = merged[DST_LD];
  assign long_nxt = merged[DST_LONG];

  always_comb begin
    if (!conn_en[K_GO_LONG]) oe_nxt = '0;
    else if (tri_mode)       oe_nxt = merged[DST_LD];
    else                     oe_nxt = '1;
  end
endmodule

// File: rtl/route_junction.sv
module route_junction
  import junction_pkg::*;
#(
  parameter int unsigned W = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_CONN-1:0] conn_en,
  input  logic              reg_out,
  input  logic              tri_mode,
  input  logic [W-1:0]      gate_out,
  input  logic [W-1:0]      ru_in,
  input  logic [W-1:0]      ld_in,
  input  logic [W-1:0]      long_rd,
  output logic [W-1:0]      gate_in,
  output logic [W-1:0]      ru_out,
  output logic [W-1:0]      ld_out,
  output logic [W-1:0]      long_drv,
  output logic [W-1:0]      long_oe,
  output logic              cfg_err
);
  localparam logic [N_CONN-1:0] GI_SET = 10'b1101000101;
  localparam logic [N_CONN-1:0] RU_SET = 10'b0010010000;
  localparam logic [N_CONN-1:0] LD_SET = 10'b0000100010;

  logic [W-1:0]      src_val;
  logic [N_DEST-1:0] clash;
  logic [W-1:0]      gi_nxt, ru_nxt, ld_nxt, long_nxt, oe_nxt;

  junction_src #(.W(W)) u_src (
    .clk(clk), .rst(rst), .reg_out(reg_out),
    .gate_out(gate_out), .src_val(src_val)
  );

  junction_conflict u_conf (
    .conn_en(conn_en), .clash(clash)
  );

  junction_route #(.W(W)) u_route (
    .conn_en(conn_en), .clash(clash), .tri_mode(tri_mode),
    .src_val(src_val), .ru_in(ru_in), .ld_in(ld_in), .long_rd(long_rd),
    .gi_nxt(gi_nxt), .ru_nxt(ru_nxt), .ld_nxt(ld_nxt),
    .long_nxt(long_nxt), .oe_nxt(oe_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_in  <= '0;
      ru_out   <= '0;
      ld_out   <= '0;
      long_drv <= '0;
      long_oe  <= '0;
      cfg_err  <= 1'b0;
    end else begin
      gate_in  <= gi_nxt;
      ru_out   <= ru_nxt;
      ld_out   <= ld_nxt;
      long_drv <= long_nxt;
      long_oe  <= oe_nxt;
      cfg_err  <= |clash;
    end
  end

  // R7: doubled gate-input drive flags and mutes the gate input
  p_gi_clash_r7: assert property (@(posedge clk) disable iff (rst)
    (conn_en[K_GO_GI_A] && conn_en[K_RU_GI]) |=> (cfg_err && gate_in == '0));

  // R7: doubled down/left drive flags and mutes the down/left output
  p_ld_clash_r7: assert property (@(posedge clk) disable iff (rst)
    (conn_en[K_LD_LD] && conn_en[K_GO_LD]) |=> (cfg_err && ld_out == '0));

  // R7: a legal word never raises the flag
  p_legal_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    ($countones(conn_en & GI_SET) <= 1 && $countones(conn_en & RU_SET) <= 1 &&
     $countones(conn_en & LD_SET) <= 1) |=> !cfg_err);

  // R8: long driver silent without bit 3
  p_long_off_r8: assert property (@(posedge clk) disable iff (rst)
    !conn_en[K_GO_LONG] |=> (long_oe == '0 && long_drv == '0));

  // R8: plain mode fully enables the long driver
  p_long_plain_r8: assert property (@(posedge clk) disable iff (rst)
    (conn_en[K_GO_LONG] && !tri_mode) |=> (long_oe == '1));
endmodule

// File: tb/route_junction_tb.sv
module route_junction_tb;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [9:0]   conn_en = '0;
  logic         reg_out = 1'b0, tri_mode = 1'b0;
  logic [W-1:0] gate_out = '0, ru_in = '0, ld_in = '0, long_rd = '0;
  logic [W-1:0] gate_in, ru_out, ld_out, long_drv, long_oe;
  logic         cfg_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  route_junction #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .conn_en(conn_en), .reg_out(reg_out),
    .tri_mode(tri_mode), .gate_out(gate_out), .ru_in(ru_in), .ld_in(ld_in),
    .long_rd(long_rd), .gate_in(gate_in), .ru_out(ru_out), .ld_out(ld_out),
    .long_drv(long_drv), .long_oe(long_oe), .cfg_err(cfg_err)
  );

  // Behavioural reference model
  logic [W-1:0] m_gi = '0, m_ru = '0, m_ld = '0, m_long = '0, m_oe = '0, m_q = '0;
  logic         m_err = 1'b0;

  always @(posedge clk) begin
    logic [W-1:0] s, gv, rv, lv;
    int ng, nr, nl;
    if (rst) begin
      m_gi = '0; m_ru = '0; m_ld = '0; m_long = '0; m_oe = '0; m_err = 1'b0; m_q = '0;
    end else begin
      s = reg_out ? m_q : gate_out;
      ng = 0; nr = 0; nl = 0; gv = '0; rv = '0; lv = '0;
      if (conn_en[0]) begin ng++; gv = s;        end
      if (conn_en[2]) begin ng++; gv = s;        end
      if (conn_en[6]) begin ng++; gv = ~ld_in;   end
      if (conn_en[8]) begin ng++; gv = long_rd;  end
      if (conn_en[9]) begin ng++; gv = ~ru_in;   end
      if (conn_en[4]) begin nr++; rv = ~ru_in;   end
      if (conn_en[7]) begin nr++; rv = s;        end
      if (conn_en[1]) begin nl++; lv = ~ld_in;   end
      if (conn_en[5]) begin nl++; lv = s;        end
      m_gi = (ng == 1) ? gv : '0;
      m_ru = (nr == 1) ? rv : '0;
      m_ld = (nl == 1) ? lv : '0;
      m_long = conn_en[3] ? s : '0;
      m_oe = !conn_en[3] ? '0 : (tri_mode ? m_ld : '1);
      m_err = (ng > 1) || (nr > 1) || (nl > 1);
      m_q = gate_out;
    end
  end

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Model comparison, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      chk("R2 gate_in", gate_in, m_gi);
      chk("R3 ru_out", ru_out, m_ru);
      chk("R3 ld_out", ld_out, m_ld);
      chk("R8 long_drv", long_drv, m_long);
      chk("R9 long_oe", long_oe, m_oe);
      chk("R7 cfg_err", {3'b000, cfg_err}, {3'b000, m_err});
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) tick();
    // R1: reset state
    chk("R1 gate_in", gate_in, '0);
    chk("R1 long_oe", long_oe, '0);
    chk("R1 cfg_err", {3'b0, cfg_err}, 4'b0);
    rst = 1'b0;
    // R3 / R5: up/right into gate input inverts, one cycle later
    conn_en = 10'b10_0000_0000; ru_in = 4'b0011;
    #1 chk("R5 before edge", gate_in, 4'b0000);
    tick();
    chk("R3 inverted ru", gate_in, 4'b1100);
    // R10: long line read back
    conn_en = 10'b01_0000_0000; long_rd = 4'b1010;
    tick();
    chk("R10 long_rd", gate_in, 4'b1010);
    // R6: registered gate output
    conn_en = 10'b00_0000_0001; reg_out = 1'b1; gate_out = 4'b0101;
    tick();
    gate_out = 4'b1001;
    tick();
    chk("R6 registered", gate_in, 4'b0101);
    reg_out = 1'b0;
    // R4: nothing enabled
    conn_en = '0;
    tick();
    chk("R4 gate_in idle", gate_in, '0);
    chk("R4 long_oe idle", long_oe, '0);
    // R9: tristate enable follows ld_out
    conn_en = 10'b00_0010_1000; tri_mode = 1'b1; gate_out = 4'b0110;
    tick();
    chk("R9 oe from ld", long_oe, 4'b0110);
    // R7: ld conflict mutes ld and tristate enable, gate input still works
    conn_en = 10'b10_0010_1010; ru_in = 4'b0001;
    tick();
    chk("R7 err", {3'b0, cfg_err}, 4'b0001);
    chk("R7 ld muted", ld_out, '0);
    chk("R7 gi kept", gate_in, 4'b1110);
    chk("R9 oe muted", long_oe, '0);
    // Mixed patterns against the model
    for (int n = 0; n < 600; n++) begin
      conn_en  = 10'($urandom);
      if (n % 3 == 0) conn_en = conn_en & 10'($urandom);
      reg_out  = 1'($urandom);
      tri_mode = 1'($urandom);
      gate_out = W'($urandom);
      ru_in    = W'($urandom);
      ld_in    = W'($urandom);
      long_rd  = W'($urandom);
      if (n == 300) rst = 1'b1;
      if (n == 302) rst = 1'b0;
      tick();
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule